// File: doc/BRIEF.md
# Address-Filtering Serial Receiver

This block receives asynchronous serial frames in which a ninth bit follows the eight data bits to mark the frame as an address (ID) frame or an ordinary data frame. Several receivers can share one line. Each station arms its filter, ignores all traffic until an ID frame arrives, reads the address, and then takes the data frames that follow. The line is oversampled sixteen times per bit. A divider in the block makes the oversample tick. The start bit is checked again at mid-bit, so short glitches do not start a frame.

A received byte leaves through a valid/ready stream port. The byte and `rx_valid` stay put until the consumer takes it with `rx_valid && rx_ready` on a clock edge. Back-pressure never stalls the serial line. If a new accepted frame completes while the old byte is still waiting, the old byte is kept and an overrun is flagged. Framing, parity and overrun flags drive a receive-error interrupt. The receive-data interrupt follows `rx_valid`. A transmit-end interrupt enable gates a transmit-end status input.

Top module: `mp_rx_top`

## Requirements
- R1: A frame is one low start bit, then 8 data bits sent LSB first, then one parity bit (only when `par_en` is 1), then the multiprocessor bit, then one stop bit. Each bit is sampled at its middle. An accepted frame loads its byte onto `rx_data` and raises `rx_valid` and `rxi_irq`.
- R2: While `rx_valid` is 1 and `rx_ready` is 0, `rx_valid` and `rx_data` do not change. A clock edge with both `rx_valid` and `rx_ready` at 1 consumes the byte, and `rx_valid` drops.
- R3: If an accepted frame completes while an unconsumed byte is waiting, `ore` is set and `rx_data` keeps the older byte.
- R4: If the stop bit is sampled low on an accepted frame, `fer` is set. The byte is still delivered.
- R5: With `par_en` at 1, the parity bit must equal the XOR of the data bits when `par_odd` is 0, and its inverse when `par_odd` is 1. A mismatch sets `per`.
- R6: A low pulse on `rxd` that has gone high again by the middle of the start bit starts no frame.
- R7: With filtering off, every frame is accepted and `mp_flag` takes that frame's multiprocessor bit.
- R8: While `filt_en` is 1, a frame whose multiprocessor bit is 0 is discarded. `rx_data`, `rx_valid`, `fer`, `per`, `ore` and `mp_flag` keep their values, and neither `rxi_irq` nor `eri_irq` rises.
- R9: While `filt_en` is 1, a frame whose multiprocessor bit is 1 is accepted. `mp_flag` becomes 1 and `filt_en` clears itself, so later frames are received normally.
- R10: A pulse on `cfg_wr` loads `filt_en` from `cfg_filt` and `teie` from `cfg_teie`. Writing 0 turns filtering off. Both bits reset to 0.
- R11: `flag_clr[0]` clears `fer`, `flag_clr[1]` clears `per`, and `flag_clr[2]` clears `ore`. When a set and a clear fall in the same cycle, the set wins.
- R12: `tei_irq` is 1 exactly when `teie` and `tx_end` are both 1.
- R13: `eri_irq` is 1 whenever any of `fer`, `per` or `ore` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial line, idles high |
| par_en | input | 1 | Parity bit is present in the frame |
| par_odd | input | 1 | Odd parity when 1, even when 0 |
| cfg_wr | input | 1 | Write strobe for the control bits |
| cfg_filt | input | 1 | Filter enable value to write |
| cfg_teie | input | 1 | Transmit-end interrupt enable value to write |
| flag_clr | input | 3 | Clear strobes: bit 0 fer, bit 1 per, bit 2 ore |
| tx_end | input | 1 | Transmit-end status from the transmit side |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Byte waiting to be consumed |
| rx_ready | input | 1 | Consumer takes the byte |
| fer | output | 1 | Framing error flag |
| per | output | 1 | Parity error flag |
| ore | output | 1 | Overrun flag |
| mp_flag | output | 1 | Multiprocessor bit of the last accepted frame |
| filt_en | output | 1 | Address filter armed |
| teie | output | 1 | Transmit-end interrupt enable |
| rxi_irq | output | 1 | Receive-data interrupt |
| eri_irq | output | 1 | Receive-error interrupt |
| tei_irq | output | 1 | Transmit-end interrupt |

## Verification
Some internal faults show up on the stream port at once. A deserializer that is off by one oversample shows, within one frame, as a shifted or corrupted byte, a spurious `fer`, or a missing delivery. Faults in the filter state take longer to surface. If the filter does not clear itself, the next data frame is lost: `rx_valid` stays low, and `filt_en` still reads 1 a few cycles after that frame's stop bit. If the filter fails to suppress, a discarded frame shows up as an unexpected byte or an error flag. The bench therefore checks the flags and `rx_data` after every frame, and a scoreboard matches each delivered byte against the frames that should have passed.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
  parameter int unsigned DATA_W = 8;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_MPB,
    S_STOP
  } rx_state_e;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              par_bit;
    logic              mp_bit;
    logic              stop_ok;
  } frame_t;
endpackage

// File: rtl/mpr_tick_gen.sv
module mpr_tick_gen #(
  parameter int unsigned CLK_DIV = 27
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [CW-1:0] cnt;

  generate
    if (CLK_DIV <= 1) begin : g_every
      assign tick = 1'b1;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= '0;
      end
    end else begin : g_div
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt  <= '0;
        end else if (cnt == CW'(CLK_DIV - 1)) begin
          cnt  <= '0;
        end else begin
          cnt  <= cnt + 1'b1;
        end
      end
      assign tick = (cnt == CW'(CLK_DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/mpr_deser.sv
module mpr_deser
  import mpr_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick,
  input  logic   rxd,
  input  logic   par_en,
  output logic   done,
  output frame_t frame
);
  localparam int unsigned OW   = $clog2(OVS);
  localparam int unsigned MID  = OVS / 2 - 1;
  localparam int unsigned LAST = OVS - 1;
  localparam int unsigned BW   = $clog2(DATA_W);

  logic              sync1, rx_s, rx_prev;
  rx_state_e         state;
  logic [OW-1:0]     os_cnt;
  logic [BW-1:0]     bit_idx;
  logic [DATA_W-1:0] shreg;
  logic              par_q, mp_q, stop_q;
  logic              at_last;

  assign at_last = (os_cnt == OW'(LAST));

  // two-flop synchronizer, idle level high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b1;
      rx_s  <= 1'b1;
    end else begin
      sync1 <= rxd;
      rx_s  <= sync1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      rx_prev <= 1'b1;
      os_cnt  <= '0;
      bit_idx <= '0;
      shreg   <= '0;
      par_q   <= 1'b0;
      mp_q    <= 1'b0;
      stop_q  <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        rx_prev <= rx_s;
        unique case (state)
          S_IDLE: begin
            if (rx_prev && !rx_s) begin
              state  <= S_START;
              os_cnt <= '0;
            end
          end
          S_START: begin
            if (os_cnt == OW'(MID)) begin
              os_cnt  <= '0;
              bit_idx <= '0;
              state   <= rx_s ? S_IDLE : S_DATA;
            end else begin
              os_cnt <= os_cnt + 1'b1;
            end
          end
          S_DATA: begin
            if (at_last) begin
              os_cnt  <= '0;
              shreg   <= {rx_s, shreg[DATA_W-1:1]};
              bit_idx <= bit_idx + 1'b1;
              if (bit_idx == BW'(DATA_W - 1))
                state <= par_en ? S_PAR : S_MPB;
            end else begin
              os_cnt <= os_cnt + 1'b1;
            end
          end
          S_PAR: begin
            if (at_last) begin
              os_cnt <= '0;
              par_q  <= rx_s;
              state  <= S_MPB;
            end else begin
              os_cnt <= os_cnt + 1'b1;
            end
          end
          S_MPB: begin
            if (at_last) begin
              os_cnt <= '0;
              mp_q   <= rx_s;
              state  <= S_STOP;
            end else begin
              os_cnt <= os_cnt + 1'b1;
            end
          end
          S_STOP: begin
            if (at_last) begin
              os_cnt <= '0;
              stop_q <= rx_s;
              done   <= 1'b1;
              state  <= S_IDLE;
            end else begin
              os_cnt <= os_cnt + 1'b1;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assign frame.data    = shreg;
  assign frame.par_bit = par_q;
  assign frame.mp_bit  = mp_q;
  assign frame.stop_ok = stop_q;
endmodule

// File: rtl/mpr_status.sv
module mpr_status
  import mpr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  frame_t            frame,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              cfg_wr,
  input  logic              cfg_filt,
  input  logic              cfg_teie,
  input  logic [2:0]        flag_clr,
  input  logic              rd_fire,
  output logic [DATA_W-1:0] hold,
  output logic              full,
  output logic              fer,
  output logic              per,
  output logic              ore,
  output logic              mp_flag,
  output logic              filt_en,
  output logic              teie
);
  logic accept, perr, busy;

  assign accept = !filt_en || frame.mp_bit;
  assign perr   = par_en && (frame.par_bit != ((^frame.data) ^ par_odd));
  assign busy   = full && !rd_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold    <= '0;
      full    <= 1'b0;
      fer     <= 1'b0;
      per     <= 1'b0;
      ore     <= 1'b0;
      mp_flag <= 1'b0;
      filt_en <= 1'b0;
      teie    <= 1'b0;
    end else begin
      if (rd_fire)     full <= 1'b0;
      if (flag_clr[0]) fer  <= 1'b0;
      if (flag_clr[1]) per  <= 1'b0;
      if (flag_clr[2]) ore  <= 1'b0;
      if (cfg_wr) begin
        filt_en <= cfg_filt;
        teie    <= cfg_teie;
      end
      if (done && accept) begin
        mp_flag <= frame.mp_bit;
        if (filt_en && !cfg_wr) filt_en <= 1'b0;
        if (busy) begin
          ore <= 1'b1;
        end else begin
          hold <= frame.data;
          full <= 1'b1;
          if (!frame.stop_ok) fer <= 1'b1;
          if (perr)           per <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mp_rx_top.sv
module mp_rx_top
  import mpr_pkg::*;
#(
  parameter int unsigned CLK_DIV = 27,
  parameter int unsigned OVS     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              cfg_wr,
  input  logic              cfg_filt,
  input  logic              cfg_teie,
  input  logic [2:0]        flag_clr,
  input  logic              tx_end,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              fer,
  output logic              per,
  output logic              ore,
  output logic              mp_flag,
  output logic              filt_en,
  output logic              teie,
  output logic              rxi_irq,
  output logic              eri_irq,
  output logic              tei_irq
);
  logic   os_tick;
  logic   frame_done;
  frame_t frame;
  logic   frame_mp;
  logic   full;
  logic   rd_fire;

  mpr_tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (os_tick)
  );

  mpr_deser #(.OVS(OVS)) u_deser (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (os_tick),
    .rxd   (rxd),
    .par_en(par_en),
    .done  (frame_done),
    .frame (frame)
  );

  assign frame_mp = frame.mp_bit;
  assign rd_fire  = full && rx_ready;

  mpr_status u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .done    (frame_done),
    .frame   (frame),
    .par_en  (par_en),
    .par_odd (par_odd),
    .cfg_wr  (cfg_wr),
    .cfg_filt(cfg_filt),
    .cfg_teie(cfg_teie),
    .flag_clr(flag_clr),
    .rd_fire (rd_fire),
    .hold    (rx_data),
    .full    (full),
    .fer     (fer),
    .per     (per),
    .ore     (ore),
    .mp_flag (mp_flag),
    .filt_en (filt_en),
    .teie    (teie)
  );

  assign rx_valid = full;
  assign rxi_irq  = full;
  assign eri_irq  = fer | per | ore;
  assign tei_irq  = teie & tx_end;
endmodule

// File: rtl/mp_rx_top_chk.sv
module mp_rx_top_chk
  import mpr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              frame_done,
  input logic              frame_mp,
  input logic              cfg_wr,
  input logic              cfg_filt,
  input logic [2:0]        flag_clr,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              fer,
  input logic              per,
  input logic              ore,
  input logic              mp_flag,
  input logic              filt_en
);
  a_r2_hold_under_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  a_r3_overrun_keeps_old: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && rx_valid && !rx_ready && (!filt_en || frame_mp)) |=> (ore && $stable(rx_data)));

  a_r8_filtered_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && filt_en && !frame_mp && flag_clr == 3'b000)
      |=> ($stable(fer) && $stable(per) && $stable(ore) && $stable(rx_data)
           && $stable(mp_flag) && !$rose(rx_valid)));

  a_r9_id_frame_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && filt_en && frame_mp && !cfg_wr) |=> (!filt_en && mp_flag));

  a_r10_write_loads_filter: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (filt_en == $past(cfg_filt)));
endmodule

bind mp_rx_top mp_rx_top_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frame_done(frame_done),
  .frame_mp  (frame_mp),
  .cfg_wr    (cfg_wr),
  .cfg_filt  (cfg_filt),
  .flag_clr  (flag_clr),
  .rx_data   (rx_data),
  .rx_valid  (rx_valid),
  .rx_ready  (rx_ready),
  .fer       (fer),
  .per       (per),
  .ore       (ore),
  .mp_flag   (mp_flag),
  .filt_en   (filt_en)
);

// File: tb/mp_rx_top_test.sv
module mp_rx_top_test;
  localparam int CLK_DIV = 2;
  localparam int BITC    = 16 * CLK_DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       par_en = 1'b0, par_odd = 1'b0;
  logic       cfg_wr = 1'b0, cfg_filt = 1'b0, cfg_teie = 1'b0;
  logic [2:0] flag_clr = 3'b000;
  logic       tx_end = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid, rx_ready = 1'b1;
  logic       fer, per, ore, mp_flag, filt_en, teie, rxi_irq, eri_irq, tei_irq;

  int checks = 0, failures = 0;
  logic [7:0] exp_q[$];
  bit finished = 0;

  always #4 clk = ~clk;

  mp_rx_top #(.CLK_DIV(CLK_DIV)) uut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .par_en(par_en), .par_odd(par_odd),
    .cfg_wr(cfg_wr), .cfg_filt(cfg_filt), .cfg_teie(cfg_teie), .flag_clr(flag_clr),
    .tx_end(tx_end), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .fer(fer), .per(per), .ore(ore), .mp_flag(mp_flag), .filt_en(filt_en),
    .teie(teie), .rxi_irq(rxi_irq), .eri_irq(eri_irq), .tei_irq(tei_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // scoreboard monitor: every consumed byte must match the oldest expectation
  always @(negedge clk) begin
    if (rst_n && rx_valid && rx_ready) begin
      if (exp_q.size() == 0) begin
        chk("R1 unexpected byte", {24'd0, rx_data}, 32'hFFFF_FFFF);
      end else begin
        chk("R1 R2 stream byte", {24'd0, rx_data}, {24'd0, exp_q.pop_front()});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  task automatic tx_bit(input logic b);
    rxd = b;
    repeat (BITC) @(posedge clk);
    #1;
  endtask

  task automatic send(input logic [7:0] d, input logic mp, input logic stop,
                      input logic par_flip, input logic expect_out);
    @(posedge clk); #1;
    if (expect_out) exp_q.push_back(d);
    tx_bit(1'b0);
    for (int i = 0; i < 8; i++) tx_bit(d[i]);
    if (par_en) tx_bit((^d) ^ par_odd ^ par_flip);
    tx_bit(mp);
    tx_bit(stop);
    tx_bit(1'b1);
    tx_bit(1'b1);
    @(negedge clk);
  endtask

  task automatic cfg(input logic f, input logic t);
    @(posedge clk); #1;
    cfg_wr = 1'b1; cfg_filt = f; cfg_teie = t;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic clr(input logic [2:0] m);
    @(posedge clk); #1;
    flag_clr = m;
    @(posedge clk); #1;
    flag_clr = 3'b000;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R2 reset valid", rx_valid, 0);
    chk("R10 reset filt_en", filt_en, 0);
    chk("R10 reset teie", teie, 0);
    chk("R7 reset mp_flag", mp_flag, 0);
    chk("R13 reset eri", eri_irq, 0);

    // R1 / R7: normal reception with filter off
    send(8'h5A, 1'b0, 1'b1, 1'b0, 1'b1);
    chk("R7 mp_flag after mp=0", mp_flag, 0);
    send(8'hC3, 1'b1, 1'b1, 1'b0, 1'b1);
    chk("R7 mp_flag after mp=1", mp_flag, 1);
    send(8'h0F, 1'b0, 1'b1, 1'b0, 1'b1);
    chk("R7 mp_flag back to 0", mp_flag, 0);
    chk("R1 data held", rx_data, 8'h0F);

    // R10 arm filter
    cfg(1'b1, 1'b0);
    chk("R10 filter armed", filt_en, 1);

    // R8 filtered frame with bad stop bit: nothing changes
    rx_ready = 1'b0;
    send(8'h11, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R8 no valid", rx_valid, 0);
    chk("R8 no rxi", rxi_irq, 0);
    chk("R8 fer unchanged", fer, 0);
    chk("R8 eri unchanged", eri_irq, 0);
    chk("R8 rx_data unchanged", rx_data, 8'h0F);
    chk("R8 mp_flag unchanged", mp_flag, 0);
    chk("R8 filter still armed", filt_en, 1);
    rx_ready = 1'b1;

    // R9 ID frame accepted and filter disarms
    send(8'h42, 1'b1, 1'b1, 1'b0, 1'b1);
    chk("R9 filter cleared", filt_en, 0);
    chk("R9 mp_flag set", mp_flag, 1);
    send(8'h77, 1'b0, 1'b1, 1'b0, 1'b1);
    chk("R9 later data accepted mp_flag", mp_flag, 0);

    // R10 software clear
    cfg(1'b1, 1'b0);
    cfg(1'b0, 1'b0);
    chk("R10 write 0 clears", filt_en, 0);

    // R3 / R2 overrun under back-pressure
    rx_ready = 1'b0;
    send(8'hA5, 1'b0, 1'b1, 1'b0, 1'b1);
    chk("R2 valid waiting", rx_valid, 1);
    send(8'h3C, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R3 ore set", ore, 1);
    chk("R3 old byte kept", rx_data, 8'hA5);
    chk("R13 eri on ore", eri_irq, 1);
    chk("R2 still valid", rx_valid, 1);
    @(posedge clk); #1 rx_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 consumed", rx_valid, 0);
    clr(3'b100);
    chk("R11 ore cleared", ore, 0);
    chk("R13 eri clear", eri_irq, 0);

    // R4 framing error, byte still delivered
    send(8'h99, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R4 fer set", fer, 1);
    chk("R13 eri on fer", eri_irq, 1);
    clr(3'b001);
    chk("R11 fer cleared", fer, 0);

    // R5 parity
    par_en = 1'b1; par_odd = 1'b0;
    send(8'h35, 1'b0, 1'b1, 1'b0, 1'b1);
    chk("R5 even good", per, 0);
    send(8'h35, 1'b0, 1'b1, 1'b1, 1'b1);
    chk("R5 even bad", per, 1);
    clr(3'b010);
    chk("R11 per cleared", per, 0);
    par_odd = 1'b1;
    send(8'hE1, 1'b1, 1'b1, 1'b0, 1'b1);
    chk("R5 odd good", per, 0);
    chk("R1 parity frame mp bit", mp_flag, 1);
    par_en = 1'b0; par_odd = 1'b0;

    // R6 glitch rejection
    rx_ready = 1'b0;
    @(posedge clk); #1 rxd = 1'b0;
    repeat (4) @(posedge clk);
    #1 rxd = 1'b1;
    repeat (12 * BITC) @(posedge clk);
    @(negedge clk);
    chk("R6 glitch ignored", rx_valid, 0);
    rx_ready = 1'b1;

    // R12 transmit-end interrupt gating
    tx_end = 1'b1;
    @(negedge clk);
    chk("R12 tei gated off", tei_irq, 0);
    cfg(1'b0, 1'b1);
    chk("R12 tei on", tei_irq, 1);
    tx_end = 1'b0;
    @(negedge clk);
    chk("R12 tei follows tx_end", tei_irq, 0);

    repeat (4) @(negedge clk);
    chk("R1 scoreboard drained", exp_q.size(), 0);
    summary();
  end
endmodule